// File: doc/BRIEF.md
# Command Packet Decoder with Register File

This block sits behind a host link that has already removed the link scrambling, so what it sees is a stream of plain command bytes. A byte flagged as start opens a packet and a byte flagged as end closes it; a packet may carry at most 64 bytes. When a packet closes, the block reads the opcode in its first byte. It checks any fixed cookie bytes, the count and the length, and then acts on the packet or throws it away.

Three commands reach internal state. A batched write stores a list of address/value pairs into a 256-entry byte register file. A single read returns one register byte. A synchronous abort is acknowledged with the bitwise complement of its pattern byte. Replies leave as single bytes with a one-cycle valid strobe. Any packet that fails its checks, and any opcode the block does not know, raises a one-cycle error pulse and leaves the register file untouched. Other known commands belong to blocks outside this one: they are accepted with no side effect. While the block is working through a packet it raises a busy output, and bytes offered during that time are dropped.

Top module: `cmd_pkt_decoder`

## Requirements
- R1: After reset, busy_o, rsp_valid_o and err_o are low, and every register from address 1 to 255 reads 0x00.
- R2: A packet 0x80, N, then N address/value pairs writes the pairs into the register file in packet order, one per clock. A later pair to the same address overrides an earlier one.
- R3: A 0x80 packet whose N lies outside 1..31, or whose length differs from 2*(N+1) bytes, is discarded: no register changes, and err_o pulses for one cycle in the second cycle after the end byte is taken.
- R4: A packet 0x81, 0x01, address of exactly 3 bytes produces one reply byte holding that register's value, with rsp_valid_o high for one cycle in the second cycle after the end byte is taken. A wrong second byte or a wrong length raises err_o and gives no reply.
- R5: The 2-byte packet 0x7D, 0x55 is answered with the reply byte 0xAA. Any other second byte, or any other length, raises err_o and gives no reply.
- R6: An EEPROM read (0x07, length exactly 5, bytes 1 and 2 equal to 0x33 and 0x81) and an EEPROM write (0x06, length at least 5, bytes 1 and 2 equal to 0x42 and 0x55) are accepted with no reply and no error. A wrong cookie or a wrong length raises err_o.
- R7: The opcodes 0x01, 0x02, 0x7A, 0x7B, 0x7C, 0x7E, 0x7F and 0x82 are accepted with no error, no reply and no register change. Any opcode not listed in R2 to R7 raises err_o and has no other effect.
- R8: A packet of more than 64 bytes is discarded with an err_o pulse, and none of its pairs are written.
- R9: Writes to address 0 are ignored. Address 0 reads 0x10 while ready_i is high and 0x00 while ready_i is low.
- R10: After a valid batched write of N pairs, busy_o stays high for exactly N+1 cycles: one check cycle, then one cycle per pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ready_i | input | 1 | Bring-up complete; selects the value address 0 reads |
| in_valid_i | input | 1 | Command byte valid |
| in_data_i | input | 8 | Command byte |
| in_sop_i | input | 1 | Byte is the first of a packet |
| in_eop_i | input | 1 | Byte is the last of a packet |
| busy_o | output | 1 | Packet being checked or applied; input bytes are dropped |
| rsp_valid_o | output | 1 | Reply byte valid (one cycle) |
| rsp_data_o | output | 8 | Reply byte |
| err_o | output | 1 | Packet rejected (one-cycle pulse) |

## Verification
The bench goes after batched writes that hit the same address more than once. A design that applied pairs out of order, or in parallel, would leave an earlier value behind. It sends counts of 0, 32 and counts that disagree with the length, plus a 66-byte packet. A decoder that wrote pairs before checking the whole packet would corrupt registers that the bench reads back afterwards. It tries wrong cookies, wrong abort patterns and unknown opcodes, where a loose decoder would stay silent or reply. It also counts busy cycles and the reply cycle, and it reads address 0 on both sides of ready_i, where a stored register would show a written value.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam logic [7:0] OP_START      = 8'h01;
  localparam logic [7:0] OP_ABORT_ASYN = 8'h02;
  localparam logic [7:0] OP_EE_WR      = 8'h06;
  localparam logic [7:0] OP_EE_RD      = 8'h07;
  localparam logic [7:0] OP_LED_TBL    = 8'h7A;
  localparam logic [7:0] OP_LED_MODE   = 8'h7B;
  localparam logic [7:0] OP_BOOT       = 8'h7C;
  localparam logic [7:0] OP_ABORT_SYNC = 8'h7D;
  localparam logic [7:0] OP_BS_INIT    = 8'h7E;
  localparam logic [7:0] OP_BS_DATA    = 8'h7F;
  localparam logic [7:0] OP_REG_WR     = 8'h80;
  localparam logic [7:0] OP_REG_RD     = 8'h81;
  localparam logic [7:0] OP_REVID      = 8'h82;

  localparam logic [7:0] EE_RD_KEY0  = 8'h33;
  localparam logic [7:0] EE_RD_KEY1  = 8'h81;
  localparam logic [7:0] EE_WR_KEY0  = 8'h42;
  localparam logic [7:0] EE_WR_KEY1  = 8'h55;
  localparam logic [7:0] ABORT_PAT   = 8'h55;
  localparam logic [7:0] RD_ONE      = 8'h01;
  localparam logic [7:0] STATUS_UP   = 8'h10;

  typedef enum logic [1:0] {ACT_NONE, ACT_WRITE, ACT_READ, ACT_ABORT} act_e;
  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_APPLY} state_e;
endpackage

// File: rtl/cmd_rx_buffer.sv
module cmd_rx_buffer #(
  parameter int DEPTH = 64
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           valid_i,
  input  logic                           sop_i,
  input  logic                           eop_i,
  input  logic [7:0]                     data_i,
  output logic                           done_o,
  output logic [$clog2(DEPTH+1)-1:0]     len_o,
  output logic                           ovf_o,
  output logic [7:0]                     byte_o [DEPTH]
);
  localparam int LEN_W = $clog2(DEPTH+1);
  localparam int PTR_W = $clog2(DEPTH);

  logic             active_q;
  logic [LEN_W-1:0] len_q;
  logic             ovf_q;
  logic             take_first, take_next, full;

  assign take_first = valid_i & sop_i;
  assign take_next  = valid_i & ~sop_i & active_q;
  assign full       = (len_q == LEN_W'(DEPTH));
  assign done_o     = (take_first | take_next) & eop_i;
  assign len_o      = len_q;
  assign ovf_o      = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      len_q    <= '0;
      ovf_q    <= 1'b0;
    end else if (take_first) begin
      len_q    <= LEN_W'(1);
      ovf_q    <= 1'b0;
      active_q <= ~eop_i;
    end else if (take_next) begin
      if (full) ovf_q <= 1'b1;
      else      len_q <= len_q + LEN_W'(1);
      if (eop_i) active_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i) begin
    if (take_first)               byte_o[0] <= data_i;
    else if (take_next && !full)  byte_o[len_q[PTR_W-1:0]] <= data_i;
  end

  assert_len_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    len_q <= LEN_W'(DEPTH))
    else $error("packet length counter past depth");
endmodule

// File: rtl/cmd_validate.sv
module cmd_validate
  import cmd_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic [7:0]                   op_i,
  input  logic [7:0]                   b1_i,
  input  logic [7:0]                   b2_i,
  input  logic [$clog2(DEPTH+1)-1:0]   len_i,
  input  logic                         ovf_i,
  output act_e                         act_o,
  output logic                         err_o
);
  localparam int LEN_W     = $clog2(DEPTH+1);
  localparam int MAX_PAIRS = (DEPTH - 2) / 2;

  logic [8:0] wr_len;
  assign wr_len = ({1'b0, b1_i} + 9'd1) << 1;

  always_comb begin
    act_o = ACT_NONE;
    err_o = 1'b0;
    if (ovf_i) begin
      err_o = 1'b1;
    end else begin
      unique case (op_i)
        OP_REG_WR:
          if (b1_i != 8'd0 && b1_i <= 8'(MAX_PAIRS) && 9'(len_i) == wr_len) act_o = ACT_WRITE;
          else err_o = 1'b1;
        OP_REG_RD:
          if (len_i == LEN_W'(3) && b1_i == RD_ONE) act_o = ACT_READ;
          else err_o = 1'b1;
        OP_ABORT_SYNC:
          if (len_i == LEN_W'(2) && b1_i == ABORT_PAT) act_o = ACT_ABORT;
          else err_o = 1'b1;
        OP_EE_RD:
          err_o = !(len_i == LEN_W'(5) && b1_i == EE_RD_KEY0 && b2_i == EE_RD_KEY1);
        OP_EE_WR:
          err_o = !(len_i >= LEN_W'(5) && b1_i == EE_WR_KEY0 && b2_i == EE_WR_KEY1);
        OP_START, OP_ABORT_ASYN, OP_LED_TBL, OP_LED_MODE,
        OP_BOOT, OP_BS_INIT, OP_BS_DATA, OP_REVID:
          err_o = 1'b0;
        default:
          err_o = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/cmd_regfile.sv
module cmd_regfile
  import cmd_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ready_i,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [7:0]    wd_i,
  input  logic [AW-1:0] ra_i,
  output logic [7:0]    rd_o
);
  localparam int ENTRIES = 1 << AW;

  logic [7:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) mem_q[i] <= 8'h00;
    end else if (we_i && wa_i != '0) begin
      mem_q[wa_i] <= wd_i;
    end
  end

  // address 0 is a status byte, not storage
  assign rd_o = (ra_i == '0) ? (ready_i ? STATUS_UP : 8'h00) : mem_q[ra_i];

  assert_reg0_unwritten_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_q[0] == 8'h00)
    else $error("status slot was written");
endmodule

// File: rtl/cmd_pkt_decoder.sv
module cmd_pkt_decoder
  import cmd_pkg::*;
#(
  parameter int PKT_DEPTH = 64,
  parameter int REG_AW    = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ready_i,
  input  logic       in_valid_i,
  input  logic [7:0] in_data_i,
  input  logic       in_sop_i,
  input  logic       in_eop_i,
  output logic       busy_o,
  output logic       rsp_valid_o,
  output logic [7:0] rsp_data_o,
  output logic       err_o
);
  localparam int LEN_W     = $clog2(PKT_DEPTH+1);
  localparam int PTR_W     = $clog2(PKT_DEPTH);
  localparam int MAX_PAIRS = (PKT_DEPTH - 2) / 2;
  localparam int PAIR_W    = $clog2(MAX_PAIRS+1);

  state_e            state_q;
  logic              done;
  logic [LEN_W-1:0]  len;
  logic              ovf;
  logic [7:0]        pkt [PKT_DEPTH];
  act_e              act;
  logic              bad;
  logic [PAIR_W-1:0] idx_q, npairs_q;
  logic [PTR_W-1:0]  a_ptr, d_ptr;
  logic              we;
  logic [7:0]        rd_data;

  assign busy_o = (state_q != S_IDLE);

  cmd_rx_buffer #(.DEPTH(PKT_DEPTH)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (in_valid_i & ~busy_o),
    .sop_i   (in_sop_i),
    .eop_i   (in_eop_i),
    .data_i  (in_data_i),
    .done_o  (done),
    .len_o   (len),
    .ovf_o   (ovf),
    .byte_o  (pkt)
  );

  cmd_validate #(.DEPTH(PKT_DEPTH)) u_val (
    .op_i  (pkt[0]),
    .b1_i  (pkt[1]),
    .b2_i  (pkt[2]),
    .len_i (len),
    .ovf_i (ovf),
    .act_o (act),
    .err_o (bad)
  );

  assign a_ptr = PTR_W'({idx_q, 1'b0}) + PTR_W'(2);
  assign d_ptr = a_ptr + PTR_W'(1);
  assign we    = (state_q == S_APPLY);

  cmd_regfile #(.AW(REG_AW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ready_i (ready_i),
    .we_i    (we),
    .wa_i    (pkt[a_ptr][REG_AW-1:0]),
    .wd_i    (pkt[d_ptr]),
    .ra_i    (pkt[2][REG_AW-1:0]),
    .rd_o    (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= S_IDLE;
      idx_q       <= '0;
      npairs_q    <= '0;
      rsp_valid_o <= 1'b0;
      rsp_data_o  <= 8'h00;
      err_o       <= 1'b0;
    end else begin
      rsp_valid_o <= 1'b0;
      err_o       <= 1'b0;
      unique case (state_q)
        S_IDLE:
          if (done) state_q <= S_CHECK;
        S_CHECK: begin
          state_q <= S_IDLE;
          if (bad) begin
            err_o <= 1'b1;
          end else begin
            unique case (act)
              ACT_READ:  begin rsp_valid_o <= 1'b1; rsp_data_o <= rd_data; end
              ACT_ABORT: begin rsp_valid_o <= 1'b1; rsp_data_o <= ~pkt[1]; end
              ACT_WRITE: begin
                state_q  <= S_APPLY;
                idx_q    <= '0;
                npairs_q <= pkt[1][PAIR_W-1:0];
              end
              default: ;
            endcase
          end
        end
        S_APPLY:
          if (idx_q == npairs_q - PAIR_W'(1)) state_q <= S_IDLE;
          else idx_q <= idx_q + PAIR_W'(1);
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_one_byte_reply_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o)
    else $error("reply longer than one byte");

  assert_err_no_reply_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!rsp_valid_o && !busy_o))
    else $error("rejected packet produced reply or work");

  assert_apply_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_APPLY && $past(state_q) == S_APPLY) |-> idx_q == $past(idx_q) + PAIR_W'(1))
    else $error("pairs not applied in order");

  assert_apply_entry_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_APPLY && $past(state_q) != S_APPLY) |-> ($past(state_q) == S_CHECK && idx_q == '0))
    else $error("apply phase entered without check");
endmodule

// File: tb/sim_cmd_pkt_decoder.sv
`timescale 1ns/1ps
module sim_cmd_pkt_decoder;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ready = 1'b0;
  logic       in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       busy, rsp_valid, err;
  logic [7:0] rsp_data;

  always #10 clk = ~clk;

  cmd_pkt_decoder u0 (
    .clk_i(clk), .rst_ni(rst_n), .ready_i(ready),
    .in_valid_i(in_valid), .in_data_i(in_data), .in_sop_i(in_sop), .in_eop_i(in_eop),
    .busy_o(busy), .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .err_o(err)
  );

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] pkt [0:69];
  int plen;
  logic [7:0] model [0:255];
  int obs_rsp_n, obs_rsp_at, obs_err_n, obs_err_at, obs_busy_n;
  logic [7:0] obs_rsp_d;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return ready ? 8'h10 : 8'h00;
    return model[a];
  endfunction

  task automatic send();
    for (int i = 0; i < plen; i++) begin
      @(negedge clk);
      in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == plen - 1); in_data = pkt[i];
    end
    @(negedge clk);
    in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
    obs_rsp_n = 0; obs_err_n = 0; obs_busy_n = 0; obs_rsp_at = -1; obs_err_at = -1; obs_rsp_d = 8'h00;
    for (int k = 0; k < 40; k++) begin
      if (k > 0) @(negedge clk);
      if (busy) obs_busy_n++;
      if (rsp_valid) begin obs_rsp_n++; obs_rsp_at = k; obs_rsp_d = rsp_data; end
      if (err) begin obs_err_n++; obs_err_at = k; end
    end
  endtask

  task automatic expect_err(input string tag);
    send();
    chk(obs_err_n == 1 && obs_err_at == 1, {tag, " err pulse"}, obs_err_n, 1);
    chk(obs_rsp_n == 0, {tag, " no reply"}, obs_rsp_n, 0);
  endtask

  task automatic expect_quiet(input string tag);
    send();
    chk(obs_err_n == 0 && obs_rsp_n == 0, {tag, " silent accept"}, obs_err_n + obs_rsp_n, 0);
  endtask

  task automatic rd_check(input logic [7:0] a, input string tag);
    plen = 3; pkt[0] = 8'h81; pkt[1] = 8'h01; pkt[2] = a;
    send();
    chk(obs_rsp_n == 1 && obs_rsp_at == 1 && obs_err_n == 0, {tag, " read timing"}, obs_rsp_at, 1);
    chk(obs_rsp_d == exp_read(a), {tag, " read value"}, obs_rsp_d, exp_read(a));
  endtask

  task automatic wr_pkt(input int n);
    pkt[0] = 8'h80; pkt[1] = 8'(n); plen = 2 * (n + 1);
  endtask

  task automatic model_apply(input int n);
    for (int i = 0; i < n; i++)
      if (pkt[2 + 2*i] != 8'h00) model[pkt[2 + 2*i]] = pkt[3 + 2*i];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !rsp_valid && !err, "R1 outputs after reset", {busy, rsp_valid, err}, 0);
    rd_check(8'h05, "R1");
    rd_check(8'hFF, "R1");
    rd_check(8'h00, "R9 not ready");

    ready = 1'b1;
    rd_check(8'h00, "R9 ready");
    wr_pkt(2); pkt[2] = 8'h00; pkt[3] = 8'h33; pkt[4] = 8'h07; pkt[5] = 8'h44;
    send(); model_apply(2);
    chk(obs_err_n == 0 && obs_busy_n == 3, "R10 busy for two pairs", obs_busy_n, 3);
    rd_check(8'h00, "R9 write to 0 ignored");
    rd_check(8'h07, "R2");

    // R2 same-address ordering
    wr_pkt(3); pkt[2] = 8'h09; pkt[3] = 8'h01; pkt[4] = 8'h09; pkt[5] = 8'h02; pkt[6] = 8'h09; pkt[7] = 8'h03;
    send(); model_apply(3);
    chk(obs_busy_n == 4, "R10 busy for three pairs", obs_busy_n, 4);
    rd_check(8'h09, "R2 last pair wins");

    // R3 count and length errors
    plen = 2; pkt[0] = 8'h80; pkt[1] = 8'h00;
    expect_err("R3 count zero");
    wr_pkt(2); pkt[2] = 8'h0A; pkt[3] = 8'h55; plen = 4;
    expect_err("R3 length short");
    rd_check(8'h0A, "R3 no write after short");
    wr_pkt(1); pkt[2] = 8'h0B; pkt[3] = 8'h66; pkt[4] = 8'h0C; pkt[5] = 8'h77; plen = 6;
    expect_err("R3 length long");
    rd_check(8'h0B, "R3 no write after long");
    wr_pkt(31); pkt[1] = 8'd32;
    for (int i = 0; i < 31; i++) begin pkt[2+2*i] = 8'h20 + 8'(i); pkt[3+2*i] = 8'hE0; end
    expect_err("R3 count 32");
    rd_check(8'h20, "R3 no write after count 32");

    // R8 oversize packet
    wr_pkt(32);
    for (int i = 0; i < 32; i++) begin pkt[2+2*i] = 8'h60 + 8'(i); pkt[3+2*i] = 8'hA5; end
    expect_err("R8 66 byte packet");
    rd_check(8'h60, "R8 no write");
    rd_check(8'h7F, "R8 no write tail");

    // R10 max batch
    wr_pkt(31);
    for (int i = 0; i < 31; i++) begin pkt[2+2*i] = 8'h40 + 8'(i); pkt[3+2*i] = 8'h80 + 8'(i); end
    send(); model_apply(31);
    chk(obs_busy_n == 32 && obs_err_n == 0, "R10 busy for 31 pairs", obs_busy_n, 32);
    rd_check(8'h5E, "R2 max batch");

    // R4 read format errors
    plen = 3; pkt[0] = 8'h81; pkt[1] = 8'h02; pkt[2] = 8'h07;
    expect_err("R4 bad constant");
    plen = 4; pkt[0] = 8'h81; pkt[1] = 8'h01; pkt[2] = 8'h07; pkt[3] = 8'h00;
    expect_err("R4 bad length");

    // R5 sync abort
    plen = 2; pkt[0] = 8'h7D; pkt[1] = 8'h55;
    send();
    chk(obs_rsp_n == 1 && obs_rsp_at == 1 && obs_err_n == 0, "R5 abort reply timing", obs_rsp_at, 1);
    chk(obs_rsp_d == 8'hAA, "R5 abort reply value", obs_rsp_d, 8'hAA);
    plen = 2; pkt[1] = 8'h54;
    expect_err("R5 wrong pattern");
    plen = 3; pkt[1] = 8'h55; pkt[2] = 8'h00;
    expect_err("R5 wrong length");

    // R6 EEPROM cookies
    plen = 5; pkt[0] = 8'h07; pkt[1] = 8'h33; pkt[2] = 8'h81; pkt[3] = 8'h10; pkt[4] = 8'h10;
    expect_quiet("R6 eeprom read");
    pkt[2] = 8'h80;
    expect_err("R6 eeprom read cookie");
    plen = 6; pkt[0] = 8'h06; pkt[1] = 8'h42; pkt[2] = 8'h55; pkt[3] = 8'h00; pkt[4] = 8'h01; pkt[5] = 8'hAB;
    expect_quiet("R6 eeprom write");
    pkt[1] = 8'h43;
    expect_err("R6 eeprom write cookie");

    // R7 known and unknown opcodes
    plen = 3; pkt[0] = 8'h7C; pkt[1] = 8'h07; pkt[2] = 8'h99;
    expect_quiet("R7 known opcode");
    pkt[0] = 8'h82;
    expect_quiet("R7 revision opcode");
    pkt[0] = 8'h03;
    expect_err("R7 unknown opcode");
    pkt[0] = 8'hFF;
    expect_err("R7 unknown opcode high");
    rd_check(8'h07, "R7 no side effect");

    // R9 status follows ready
    ready = 1'b0;
    rd_check(8'h00, "R9 ready dropped");
    ready = 1'b1;

    // R2 random batches against model
    for (int it = 0; it < 30; it++) begin
      int n;
      n = 1 + int'($urandom % 31);
      wr_pkt(n);
      for (int i = 0; i < n; i++) begin
        pkt[2+2*i] = (it % 2 == 0) ? 8'($urandom % 6) : 8'($urandom);
        pkt[3+2*i] = 8'($urandom);
      end
      send(); model_apply(n);
      chk(obs_busy_n == n + 1 && obs_err_n == 0, "R10 random busy", obs_busy_n, n + 1);
      for (int j = 0; j < 3; j++) rd_check(pkt[2 + 2*int'($urandom % n)], "R2 random");
      rd_check(8'($urandom % 6), "R2 random small");
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule